// File: doc/BRIEF.md
# Packed Reciprocal Square Root Estimator

This block returns a fast estimate of 1/sqrt(|b|) for one single-precision operand `b`. Only the low 32-bit word of the wide source is read. The single 32-bit estimate is copied into every 32-bit lane of the wide result. The sign of the operand plays no part in the magnitude computation, but the result carries that sign.

The estimate is built in three steps. A small seed table is addressed by exponent parity and the leading fraction bits. One multiply-based Newton correction then refines the seed. The result exponent is found by halving and negating the unbiased source exponent. Three special cases have their own outputs:
- A zero or denormal operand is flushed to zero and answered with the largest normal magnitude.
- An operand with an all-ones exponent field gets a fixed quiet-NaN pattern.
- Every other operand gets a normal result.

The unit is fully pipelined. It accepts one operand per cycle and returns each result exactly three cycles after it is presented, marked by a valid strobe.

Top module: `packed_rsqrt_est`

## Requirements
- R1: Only source bits [31:0] are used. Result lane 0 (bits [31:0]) and lane 1 (bits [63:32]) always hold the same 32-bit word, and source bits [63:32] have no effect on it.
- R2: `out_valid` rises exactly three rising edges after the edge that samples `in_valid` high. It stays low when no input was presented.
- R3: The result sign bit (bit 31 of each lane) equals source bit 31 for every operand class.
- R4: Source bits [30:23] equal to 0 (zero or denormal) give lane magnitude bits [30:0] = 0x7F7FFFFF.
- R5: Source bits [30:23] equal to 0xFF give lane magnitude bits [30:0] = 0x7FC00000.
- R6: For a normal source with exponent field e (1..254), the result exponent field [30:23] equals (380 - e) >> 1. The result is therefore a normal number.
- R7: For a normal source, the relative error of the result magnitude against the exact 1/sqrt(|b|) is below 2^-15.
- R8: While `rst` is high, and on the cycle after it is sampled, `out_valid` is 0 and `res_q` is all zeros.
- R9: Operands presented on consecutive cycles each produce their own result, in order, on consecutive cycles.
- R10: Negating the source changes only the result sign. The magnitude bits [30:0] are identical for b and -b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a source operand on `src_a` |
| src_a | input | 64 | Wide source; bits [31:0] hold the single-precision operand |
| out_valid | output | 1 | Marks a result on `res_q` |
| res_q | output | 64 | Estimate replicated into both 32-bit lanes |

## Verification
The hardest situations to reach are the two significand-range edges, where the refined value would leave the interval [1, 2):
- Exact powers of four drive the corrected value up toward 2.0.
- Significands just below 4.0 in the even-exponent range pull it just under 1.0.

The directed tests hit both edges on purpose with 1.0, 4.0, 0.25 and the all-ones-fraction operands. They also cover the smallest and largest normal exponents, where the exponent formula reaches its ends. A pseudo-random sweep of several hundred normal operands and a back-to-back stream check the accuracy bound and the result ordering across both table halves.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    localparam int FP_EXP_W  = 8;
    localparam int FP_MAN_W  = 23;
    localparam int SIG_W     = 26;             // operand significand, Q2.24, range [1,4)
    localparam int SIG_FB    = 24;
    localparam int EXP_SUM   = 380;            // result exponent = (EXP_SUM - e) >> 1
    localparam logic [30:0] MAG_MAXNORM = 31'h7F7F_FFFF;
    localparam logic [30:0] MAG_UNDEF   = 31'h7FC0_0000;

    typedef enum logic [1:0] {
        CL_NORM = 2'd0,
        CL_ZERO = 2'd1,
        CL_SPEC = 2'd2
    } opcls_e;

    typedef struct packed {
        logic                sign;
        opcls_e              cls;
        logic [FP_EXP_W-1:0] rexp;
    } rsq_tag_t;

    typedef struct packed {
        rsq_tag_t         tag;
        logic [SIG_W-1:0] sig;
    } rsq_info_t;

    function automatic logic [63:0] isqrt64(input logic [63:0] v);
        logic [63:0] r;
        logic [63:0] c;
        r = '0;
        for (int b = 31; b >= 0; b--) begin
            c = r | (64'd1 << b);
            if (c * c <= v) r = c;
        end
        return r;
    endfunction

    // Seed 2/sqrt(s) in Q1.(seed_w-1), s taken at the midpoint of the table cell.
    function automatic logic [63:0] seed_value(input int par, input int k,
                                               input int idx_w, input int seed_w);
        logic [63:0] s_mid;
        logic [63:0] num;
        s_mid = 64'((par != 0 ? 2 : 1) * ((1 << (idx_w + 1)) + 2 * k + 1));
        num   = 64'd1 << (2 * seed_w + idx_w + 1);
        return isqrt64(num / s_mid);
    endfunction

endpackage

// File: rtl/rsq_decode.sv
module rsq_decode
    import rsq_pkg::*;
#(
    parameter int IDX_W  = 7,
    parameter int SEED_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_i,
    input  logic [31:0]       word_i,
    output logic              vld_o,
    output rsq_info_t         info_o,
    output logic [SEED_W-1:0] seed_o
);
    localparam int TBL_N = 2 << IDX_W;

    logic [SEED_W-1:0] tbl [TBL_N];

    generate
        for (genvar g = 0; g < TBL_N; g++) begin : g_tbl
            localparam logic [SEED_W-1:0] SEED_G =
                SEED_W'(seed_value(g >> IDX_W, g & ((1 << IDX_W) - 1), IDX_W, SEED_W));
            assign tbl[g] = SEED_G;
        end
    endgenerate

    logic [FP_EXP_W-1:0] e_in;
    logic [FP_MAN_W-1:0] f_in;
    logic                par_even;
    logic [IDX_W:0]      idx;
    rsq_info_t           info_nx;

    always_comb begin
        e_in     = word_i[30:23];
        f_in     = word_i[22:0];
        par_even = ~e_in[0];
        idx      = {par_even, f_in[FP_MAN_W-1 -: IDX_W]};
        info_nx.tag.sign = word_i[31];
        if (e_in == '0)
            info_nx.tag.cls = CL_ZERO;
        else if (e_in == '1)
            info_nx.tag.cls = CL_SPEC;
        else
            info_nx.tag.cls = CL_NORM;
        info_nx.tag.rexp = FP_EXP_W'((9'(EXP_SUM) - {1'b0, e_in}) >> 1);
        info_nx.sig = par_even ? {1'b1, f_in, 2'b00} : {2'b01, f_in, 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            info_o <= '0;
            seed_o <= '0;
        end else begin
            vld_o  <= vld_i;
            info_o <= info_nx;
            seed_o <= tbl[idx];
        end
    end

    // R2: a stage only marks data it was handed one cycle before
    a_r2_decode_follow: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> $past(vld_i));

    // R4: a zero class only arises from an all-zero exponent field
    a_r4_zero_class: assert property (@(posedge clk) disable iff (rst)
        (vld_o && info_o.tag.cls == CL_ZERO) |-> ($past(word_i[30:23]) == 8'h00));

endmodule

// File: rtl/rsq_refine.sv
module rsq_refine
    import rsq_pkg::*;
#(
    parameter int SEED_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      vld_i,
    input  rsq_info_t                 info_i,
    input  logic [SEED_W-1:0]         seed_i,
    output logic                      vld_o,
    output rsq_tag_t                  tag_o,
    output logic [SEED_W-1:0]         seed_o,
    output logic [4+2*(SEED_W-1)-1:0] w_o
);
    localparam int SQ_FB = 2 * (SEED_W - 1);
    localparam int SQ_W  = 2 * SEED_W;
    localparam int T_W   = SIG_W + SQ_W;
    localparam int W_W   = 4 + SQ_FB;

    logic [SQ_W-1:0] sq;
    logic [T_W-1:0]  t_full;
    logic [W_W-1:0]  t_sh;
    logic [W_W-1:0]  w_nx;

    // w = 12 - s*y0^2, with y0 = 2*r0; ideally close to 8
    always_comb begin
        sq     = seed_i * seed_i;
        t_full = info_i.sig * sq;
        t_sh   = W_W'(t_full >> SIG_FB);
        w_nx   = (W_W'(12) << SQ_FB) - t_sh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            tag_o  <= '0;
            seed_o <= '0;
            w_o    <= '0;
        end else begin
            vld_o  <= vld_i;
            tag_o  <= info_i.tag;
            seed_o <= seed_i;
            w_o    <= w_nx;
        end
    end

    a_r2_refine_follow: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> $past(vld_i));

    // R7: for a normal operand the correction term stays near 8 (between 6 and 9)
    a_r7_corr_range: assert property (@(posedge clk) disable iff (rst)
        (vld_o && tag_o.cls == CL_NORM) |->
        (w_o > (W_W'(6) << SQ_FB) && w_o < (W_W'(9) << SQ_FB)));

endmodule

// File: rtl/rsq_pack.sv
module rsq_pack
    import rsq_pkg::*;
#(
    parameter int SEED_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      vld_i,
    input  rsq_tag_t                  tag_i,
    input  logic [SEED_W-1:0]         seed_i,
    input  logic [4+2*(SEED_W-1)-1:0] w_i,
    output logic                      vld_o,
    output logic [31:0]               word_o
);
    localparam int SQ_FB = 2 * (SEED_W - 1);
    localparam int W_W   = 4 + SQ_FB;
    localparam int P_W   = SEED_W + W_W;
    localparam int P_FB  = (SEED_W - 1) + SQ_FB;
    localparam int Y_SH  = P_FB + 3 - FP_MAN_W;
    localparam int Y_W   = FP_MAN_W + 2;

    logic [P_W-1:0]      prod;
    logic [Y_W-1:0]      y_q;
    logic [FP_MAN_W-1:0] frac;
    logic [31:0]         word_nx;

    // y1 = y0 * w / 8, kept as Q2.23 and clamped into [1, 2)
    always_comb begin
        prod = seed_i * w_i;
        y_q  = Y_W'(prod >> Y_SH);
        if (y_q[Y_W-1])
            frac = '1;
        else if (!y_q[Y_W-2])
            frac = '0;
        else
            frac = y_q[FP_MAN_W-1:0];
        unique case (tag_i.cls)
            CL_ZERO: word_nx = {tag_i.sign, MAG_MAXNORM};
            CL_SPEC: word_nx = {tag_i.sign, MAG_UNDEF};
            default: word_nx = {tag_i.sign, tag_i.rexp, frac};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o  <= 1'b0;
            word_o <= '0;
        end else begin
            vld_o  <= vld_i;
            word_o <= word_nx;
        end
    end

    a_r2_pack_follow: assert property (@(posedge clk) disable iff (rst)
        vld_o |-> $past(vld_i));

endmodule

// File: rtl/packed_rsqrt_est.sv
module packed_rsqrt_est
    import rsq_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int IDX_W  = 7,
    parameter int SEED_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [32*LANES-1:0]   src_a,
    output logic                  out_valid,
    output logic [32*LANES-1:0]   res_q
);
    localparam int W_W = 4 + 2 * (SEED_W - 1);

    logic              d_vld;
    rsq_info_t         d_info;
    logic [SEED_W-1:0] d_seed;
    logic              r_vld;
    rsq_tag_t          r_tag;
    logic [SEED_W-1:0] r_seed;
    logic [W_W-1:0]    r_w;
    logic [31:0]       p_word;

    rsq_decode #(.IDX_W(IDX_W), .SEED_W(SEED_W)) u_decode (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (in_valid),
        .word_i (src_a[31:0]),
        .vld_o  (d_vld),
        .info_o (d_info),
        .seed_o (d_seed)
    );

    rsq_refine #(.SEED_W(SEED_W)) u_refine (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (d_vld),
        .info_i (d_info),
        .seed_i (d_seed),
        .vld_o  (r_vld),
        .tag_o  (r_tag),
        .seed_o (r_seed),
        .w_o    (r_w)
    );

    rsq_pack #(.SEED_W(SEED_W)) u_pack (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (r_vld),
        .tag_i  (r_tag),
        .seed_i (r_seed),
        .w_i    (r_w),
        .vld_o  (out_valid),
        .word_o (p_word)
    );

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign res_q[32*l +: 32] = p_word;
        end
    endgenerate

    // R3: sign of the operand seen three cycles earlier
    a_r3_sign_kept: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (res_q[31] == $past(src_a[31], 3)));

    // R4: zero or denormal answered with the largest normal magnitude
    a_r4_zero_maxnorm: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(src_a[30:23], 3) == 8'h00) |-> (res_q[30:0] == MAG_MAXNORM));

    // R5: all-ones exponent gives the fixed undefined pattern
    a_r5_special_pattern: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(src_a[30:23], 3) == 8'hFF) |-> (res_q[30:0] == MAG_UNDEF));

    // R6: normal operand yields a normal result with the halved, negated exponent
    a_r6_exp_field: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(src_a[30:23], 3) != 8'h00 && $past(src_a[30:23], 3) != 8'hFF)
        |-> (res_q[30:23] == 8'((9'd380 - {1'b0, $past(src_a[30:23], 3)}) >> 1)));

endmodule

// File: tb/packed_rsqrt_est_bench.sv
module packed_rsqrt_est_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] src_a = '0;
    logic        out_valid;
    logic [63:0] res_q;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    packed_rsqrt_est u_packed_rsqrt_est (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .src_a     (src_a),
        .out_valid (out_valid),
        .res_q     (res_q)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // present one operand and watch the valid strobe over three edges (R2)
    task automatic run_one(input logic [63:0] src, output logic [63:0] res);
        @(negedge clk);
        src_a    = src;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        src_a    = ~src;
        chk(out_valid == 1'b0, "R2 valid early (1 edge)", 64'(out_valid), 64'd0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R2 valid early (2 edges)", 64'(out_valid), 64'd0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R2 valid at 3 edges", 64'(out_valid), 64'd1);
        res = res_q;
    endtask

    // R1, R3, R6, R7 for a normal operand, computed from the requirements
    task automatic check_norm(input logic [63:0] src, input logic [63:0] res, input string tag);
        int  e;
        int  re;
        real b;
        real ref_v;
        real act;
        real rel;
        logic [7:0] exp_field;
        e  = int'(src[30:23]);
        re = int'(res[30:23]);
        exp_field = 8'((380 - e) >> 1);
        chk(res[63:32] == res[31:0], {"R1 lanes equal ", tag}, res, {2{res[31:0]}});
        chk(res[31] == src[31], {"R3 sign ", tag}, 64'(res[31]), 64'(src[31]));
        chk(res[30:23] == exp_field, {"R6 exponent ", tag}, 64'(res[30:23]), 64'(exp_field));
        b     = (1.0 + real'(src[22:0]) / 8388608.0) * (2.0 ** real'(e - 127));
        ref_v = 1.0 / $sqrt(b);
        act   = (1.0 + real'(res[22:0]) / 8388608.0) * (2.0 ** real'(re - 127));
        rel   = (act - ref_v) / ref_v;
        if (rel < 0.0) rel = -rel;
        n_chk++;
        if (!(rel < 3.0517578125e-5)) begin
            n_fail++;
            $display("FAIL R7 %s src=%h actual=%e expected=%e", tag, src[31:0], act, ref_v);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R8 reset valid", 64'(out_valid), 64'd0);
        chk(res_q == '0, "R8 reset data", res_q, 64'd0);
        @(negedge clk);
        rst = 1'b0;
        chk(out_valid == 1'b0, "R8 after reset valid", 64'(out_valid), 64'd0);
        chk(res_q == '0, "R8 after reset data", res_q, 64'd0);
    endtask

    task automatic t_corners();
        logic [63:0] r;
        logic [31:0] v [8];
        v = '{32'h3F80_0000, 32'h4080_0000, 32'h3E80_0000, 32'h407F_FFFF,
              32'h3FFF_FFFF, 32'h0080_0000, 32'h7F7F_FFFF, 32'h4000_0000};
        foreach (v[i]) begin
            run_one({32'h0, v[i]}, r);
            check_norm({32'h0, v[i]}, r, "corner");
        end
    endtask

    task automatic t_sweep();
        logic [31:0] x;
        logic [31:0] s;
        logic [63:0] r;
        x = 32'h1234_5678;
        for (int i = 0; i < 300; i++) begin
            x = x * 32'd1664525 + 32'd1013904223;
            s = {1'b0, 8'(32'(x[30:23]) % 254 + 1), x[22:0]};
            run_one({x, s}, r);
            check_norm({x, s}, r, "sweep");
        end
    endtask

    task automatic t_sign();
        logic [63:0] rp;
        logic [63:0] rn;
        run_one(64'h0000_0000_4049_0FDB, rp);
        run_one(64'h0000_0000_C049_0FDB, rn);
        chk(rn[31] == 1'b1, "R3 negative sign", 64'(rn[31]), 64'd1);
        chk(rn[30:0] == rp[30:0], "R10 magnitude b vs -b", 64'(rn[30:0]), 64'(rp[30:0]));
        check_norm(64'h0000_0000_C049_0FDB, rn, "negative");
    endtask

    task automatic t_zero();
        logic [63:0] r;
        logic [31:0] v [4];
        logic [31:0] w;
        v = '{32'h0000_0000, 32'h8000_0000, 32'h0000_0001, 32'h807F_FFFF};
        foreach (v[i]) begin
            run_one({32'hDEAD_BEEF, v[i]}, r);
            w = {v[i][31], 31'h7F7F_FFFF};
            chk(r == {w, w}, "R4 zero/denormal max normal", r, {w, w});
        end
    endtask

    task automatic t_special();
        logic [63:0] r;
        logic [31:0] v [3];
        logic [31:0] w;
        v = '{32'h7F80_0000, 32'hFFC0_0001, 32'h7FFF_FFFF};
        foreach (v[i]) begin
            run_one({32'h0, v[i]}, r);
            w = {v[i][31], 31'h7FC0_0000};
            chk(r == {w, w}, "R5 all-ones exponent pattern", r, {w, w});
        end
    endtask

    task automatic t_high_ignored();
        logic [63:0] ra;
        logic [63:0] rb;
        run_one(64'h0000_0000_3FC0_0000, ra);
        run_one(64'hFFFF_FFFF_3FC0_0000, rb);
        chk(ra == rb, "R1 high source half ignored", rb, ra);
        chk(ra[63:32] == ra[31:0], "R1 lane copy", ra, {2{ra[31:0]}});
    endtask

    task automatic t_stream();
        logic [63:0] vin [8];
        for (int i = 0; i < 8; i++)
            vin[i] = {32'h0, 1'b0, 8'(100 + 7 * i), 23'(i * 32'h0009_1234)};
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (c >= 3 && c < 11) begin
                chk(out_valid == 1'b1, "R9 stream valid", 64'(out_valid), 64'd1);
                check_norm(vin[c-3], res_q, "R9 stream");
            end else if (c >= 11) begin
                chk(out_valid == 1'b0, "R9 stream drains", 64'(out_valid), 64'd0);
            end
            if (c < 8) begin
                in_valid = 1'b1;
                src_a    = vin[c];
            end else begin
                in_valid = 1'b0;
                src_a    = '0;
            end
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<%0d cycles", WD_CYCLES, WD_CYCLES);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_corners();
        t_sign();
        t_zero();
        t_special();
        t_high_ignored();
        t_stream();
        t_sweep();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule